// File: doc/BRIEF.md
# Clock controller register file

This block is the software-visible register bank of a clock controller. It sits in a 4 KiB window on a simple 32-bit bus that carries only whole, aligned words. It holds the clock mode word, two post-divider words, the control words of two PLLs, three clock-gating words and two power-management words. Each register has its own write mask and its own reset value. All current values leave the block as parallel outputs, so that a separate block can resolve clock frequencies from them.

The bus selects a register by word index, which is the byte address shifted right by two. Every request presented with `req_valid` is accepted in that cycle. The response arrives on the next cycle with `rsp_valid`, read data and an error flag. The mode register always sets one bit when it is written. One index returns a fixed constant. The first power-management word can be read but not written. The second one is not reachable from the bus. Any access to an index with no register, a write to a location that cannot be written, or an access that is not word-aligned raises the error flag for that response.

Top module: `clkreg_top`

## Requirements
- R1: Each request accepted with `req_valid` high gets `rsp_valid` high on the following cycle only. `rsp_valid` is low after reset and in every cycle that follows a cycle with no request.
- R2: Word index 0 (mode) stores the written data ANDed with 0x3B6FDFFF, and bit 26 is always set to one. Bit 26 of `mode_o` is therefore never zero.
- R3: Word index 1 (post-divider 0) stores the written data ANDed with 0xFF9F3FFF. Word index 2 (post-divider 1) stores all 32 bits.
- R4: Word indices 4 (main PLL) and 6 (system PLL) each store the written data ANDed with 0xBFFF3FFF.
- R5: Word indices 8, 9 and 10 are gating words 0, 1 and 2. They store all 32 bits and appear on `gate_o` bits [31:0], [63:32] and [95:64].
- R6: Word index 18 always reads 0x00004040. A write to it is flagged as an error and changes no register.
- R7: Word index 23 reads power-management word 0. A write to it is flagged as an error and leaves it unchanged. Power-management word 1 is not bus-reachable and keeps its reset value.
- R8: Reset values are: mode 0x074B0B7D, post-divider 0 0xFF870B48, post-divider 1 0x49FCFE7F, main PLL 0x04001800, system PLL 0x04043001, each gating word 0xFFFFFFFF, power-management 0 0x80209828, power-management 1 0x00AA0000.
- R9: A read of any other word index returns zero with `rsp_err` high. A write to any other word index changes no register and returns `rsp_err` high.
- R10: A request whose byte address has bits [1:0] not equal to zero is a bad access. It changes no register, reads zero and raises `rsp_err`.
- R11: A write updates the parallel outputs at the clock edge that accepts it. A read of the same index issued on the very next cycle returns the new value.
- R12: `rsp_err` is high only together with `rsp_valid`. A write response and a good read response carry no error unless a rule above flags one, and write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted the same cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and bad accesses) |
| rsp_err | output | 1 | Bad-access flag, one-cycle pulse |
| mode_o | output | 32 | Current mode word |
| pdiv0_o | output | 32 | Current post-divider 0 word |
| pdiv1_o | output | 32 | Current post-divider 1 word |
| mpll_o | output | 32 | Current main PLL control word |
| spll_o | output | 32 | Current system PLL control word |
| gate_o | output | 96 | Gating words 0..2, packed low to high |
| pm0_o | output | 32 | Power-management word 0 |
| pm1_o | output | 32 | Power-management word 1 |

## Verification
A register update and the read response for that same register can fall in consecutive edges. The write is accepted and lands at one edge, and a read of the same index is accepted at the next edge. The bench forces this by issuing a write and then a read with no idle cycle between them. It judges the result by requiring that the read response carries the freshly masked value and not the old one. It also requires that the write response, which is presented in the same cycle as the read request, is error-free.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

  localparam int DW      = 32;
  localparam int NSLOT   = 10;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int N_GATE  = 3;

  localparam int unsigned CONST_IDX  = 18;
  localparam logic [DW-1:0] CONST_WORD = 32'h0000_4040;

  typedef enum logic [SLOT_W-1:0] {
    S_MODE, S_PDIV0, S_PDIV1, S_MPLL, S_SPLL,
    S_GATE0, S_GATE1, S_GATE2, S_PM0, S_PM1
  } slot_e;

  typedef struct packed {
    logic              hit;
    logic              cst;
    logic [SLOT_W-1:0] slot;
  } dec_t;

  function automatic logic [DW-1:0] slot_mask(int s);
    case (s)
      S_MODE:           return 32'h3B6F_DFFF;
      S_PDIV0:          return 32'hFF9F_3FFF;
      S_MPLL, S_SPLL:   return 32'hBFFF_3FFF;
      S_PM0, S_PM1:     return 32'h0000_0000;
      default:          return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_force(int s);
    return (s == S_MODE) ? 32'h0400_0000 : 32'h0;
  endfunction

  function automatic logic [DW-1:0] slot_reset(int s);
    case (s)
      S_MODE:  return 32'h074B_0B7D;
      S_PDIV0: return 32'hFF87_0B48;
      S_PDIV1: return 32'h49FC_FE7F;
      S_MPLL:  return 32'h0400_1800;
      S_SPLL:  return 32'h0404_3001;
      S_PM0:   return 32'h8020_9828;
      S_PM1:   return 32'h00AA_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic slot_writable(int s);
    return !(s == S_PM0 || s == S_PM1);
  endfunction

  function automatic dec_t decode_idx(int unsigned idx);
    dec_t d;
    d.hit = 1'b1;
    d.cst = 1'b0;
    d.slot = S_MODE;
    case (idx)
      0:  d.slot = S_MODE;
      1:  d.slot = S_PDIV0;
      2:  d.slot = S_PDIV1;
      4:  d.slot = S_MPLL;
      6:  d.slot = S_SPLL;
      8:  d.slot = S_GATE0;
      9:  d.slot = S_GATE1;
      10: d.slot = S_GATE2;
      23: d.slot = S_PM0;
      CONST_IDX: begin d.hit = 1'b0; d.cst = 1'b1; end
      default:   d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output dec_t              dec,
  output logic              bad
);
  logic misaligned;
  logic wr_refused;

  assign misaligned = |addr[1:0];
  assign dec        = decode_idx(32'(addr >> 2));
  assign wr_refused = wr && (dec.cst || (dec.hit && !slot_writable(int'(dec.slot))));
  assign bad        = misaligned || (!dec.hit && !dec.cst) || wr_refused;
endmodule

// File: rtl/clkreg_field.sv
module clkreg_field #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] RESET = '0,
  parameter logic [DW-1:0] MASK  = '1,
  parameter logic [DW-1:0] FORCE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET;
    else if (we) q <= (wdata & MASK) | FORCE;
  end
endmodule

// File: rtl/clkreg_resp.sv
module clkreg_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] rdata_nxt,
  input  logic          err_nxt,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      rsp_rdata <= fire ? rdata_nxt : '0;
      rsp_err   <= fire && err_nxt;
    end
  end
endmodule

// File: rtl/clkreg_top.sv
module clkreg_top
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_err,
  output logic [DW-1:0]        mode_o,
  output logic [DW-1:0]        pdiv0_o,
  output logic [DW-1:0]        pdiv1_o,
  output logic [DW-1:0]        mpll_o,
  output logic [DW-1:0]        spll_o,
  output logic [N_GATE*DW-1:0] gate_o,
  output logic [DW-1:0]        pm0_o,
  output logic [DW-1:0]        pm1_o
);
  dec_t          dec;
  logic          bad;
  logic          wr_fire;
  logic [NSLOT-1:0] we;
  logic [DW-1:0] q [NSLOT];
  logic [DW-1:0] rd_nxt;

  clkreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .wr(req_write), .dec(dec), .bad(bad)
  );

  assign wr_fire = req_valid && req_write && !bad;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign we[s] = wr_fire && dec.hit && (dec.slot == SLOT_W'(s));
    clkreg_field #(
      .DW(DW), .RESET(slot_reset(s)), .MASK(slot_mask(s)), .FORCE(slot_force(s))
    ) u_fld (
      .clk(clk), .rst_n(rst_n), .we(we[s]), .wdata(req_wdata), .q(q[s])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (!req_write && !bad) begin
      if (dec.cst) rd_nxt = CONST_WORD;
      for (int s = 0; s < NSLOT; s++)
        if (dec.hit && dec.slot == SLOT_W'(s)) rd_nxt = q[s];
    end
  end

  clkreg_resp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .fire(req_valid), .rdata_nxt(rd_nxt), .err_nxt(bad),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  assign mode_o  = q[S_MODE];
  assign pdiv0_o = q[S_PDIV0];
  assign pdiv1_o = q[S_PDIV1];
  assign mpll_o  = q[S_MPLL];
  assign spll_o  = q[S_SPLL];
  assign gate_o  = {q[S_GATE2], q[S_GATE1], q[S_GATE0]};
  assign pm0_o   = q[S_PM0];
  assign pm1_o   = q[S_PM1];

  // R1: one response per request, one cycle later
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R12: error only inside a response
  a_r12_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  // R9: bad responses carry zero data
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));
  // R10: misaligned addresses are always flagged
  a_r10_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);
  // R2: forced mode bit never clears
  a_r2_force_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[26]);
  // R3: reserved bits of post-divider 0 stay zero
  a_r3_pdiv0_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pdiv0_o & ~slot_mask(S_PDIV0)) == '0);
  // R4: reserved bits of both PLL words stay zero
  a_r4_pll_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((mpll_o | spll_o) & ~slot_mask(S_MPLL)) == '0);
  // R7: power-management words never move
  a_r7_pm_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pm0_o) && $stable(pm1_o));
endmodule

// File: tb/clkreg_top_tb.sv
module clkreg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [31:0] mode_o, pdiv0_o, pdiv1_o, mpll_o, spll_o, pm0_o, pm1_o;
  logic [95:0] gate_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [0:31];

  always #5 clk = ~clk;

  clkreg_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mode_o(mode_o), .pdiv0_o(pdiv0_o),
    .pdiv1_o(pdiv1_o), .mpll_o(mpll_o), .spll_o(spll_o), .gate_o(gate_o),
    .pm0_o(pm0_o), .pm1_o(pm1_o)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_store(int idx);
    return idx inside {0, 1, 2, 4, 6, 8, 9, 10};
  endfunction

  function automatic logic [31:0] stored(int idx, logic [31:0] d);
    case (idx)
      0:    return (d & 32'h3B6FDFFF) | (32'h1 << 26);
      1:    return d & 32'hFF9F3FFF;
      4, 6: return d & 32'hBFFF3FFF;
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] rd_exp(int idx);
    if (idx == 18) return 32'h00004040;
    if (idx == 23) return 32'h80209828;
    return is_store(idx) ? mdl[idx] : 32'h0;
  endfunction

  function automatic bit rd_bad(int idx);
    return !(is_store(idx) || idx == 18 || idx == 23);
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[0] = 32'h074B0B7D; mdl[1] = 32'hFF870B48; mdl[2] = 32'h49FCFE7F;
    mdl[4] = 32'h04001800; mdl[6] = 32'h04043001;
    mdl[8] = '1; mdl[9] = '1; mdl[10] = '1;
  endtask

  task automatic chk_outputs(string req);
    chk({req, " mode_o"},  mode_o,  mdl[0]);
    chk({req, " pdiv0_o"}, pdiv0_o, mdl[1]);
    chk({req, " pdiv1_o"}, pdiv1_o, mdl[2]);
    chk({req, " mpll_o"},  mpll_o,  mdl[4]);
    chk({req, " spll_o"},  spll_o,  mdl[6]);
    chk({req, " gate_o"},  gate_o,  {mdl[10], mdl[9], mdl[8]});
    chk({req, " pm0_o"},   pm0_o,   32'h80209828);
    chk({req, " pm1_o"},   pm1_o,   32'h00AA0000);
  endtask

  task automatic bus_write(string req, logic [11:0] addr, logic [31:0] d, bit exp_err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({req, " wr rsp_valid"}, rsp_valid, 1'b1);
    chk({req, " wr rsp_err"}, rsp_err, exp_err);
    if (!exp_err && addr[1:0] == 2'b00 && is_store(int'(addr >> 2)))
      mdl[int'(addr >> 2)] = stored(int'(addr >> 2), d);
  endtask

  task automatic bus_read(string req, logic [11:0] addr, logic [31:0] exp, bit exp_err);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rd rsp_valid"}, rsp_valid, 1'b1);
    chk({req, " rd rsp_err"}, rsp_err, exp_err);
    chk({req, " rd data"}, rsp_rdata, exp);
    @(negedge clk);
    chk({req, " rsp_valid drops"}, rsp_valid, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
    chk_outputs("R8 reset");
    foreach (mdl[i]) if (is_store(i) || i == 18 || i == 23)
      bus_read("R8 reset read", 12'(i * 4), rd_exp(i), 1'b0);
  endtask

  task automatic t_masks();
    logic [31:0] pats [3] = '{32'hFFFFFFFF, 32'h00000000, 32'hA5C35A3C};
    int idxs [8] = '{0, 1, 2, 4, 6, 8, 9, 10};
    foreach (pats[p]) foreach (idxs[k]) begin
      bus_write("R2 R3 R4 R5 write", 12'(idxs[k] * 4), pats[p], 1'b0);
      bus_read("R2 R3 R4 R5 readback", 12'(idxs[k] * 4), rd_exp(idxs[k]), 1'b0);
    end
    chk_outputs("R5 parallel outputs");
  endtask

  task automatic t_fixed();
    bus_write("R6 write constant index", 12'd72, 32'h12345678, 1'b1);
    bus_read("R6 constant", 12'd72, 32'h00004040, 1'b0);
    bus_write("R7 write pm0", 12'd92, 32'h0, 1'b1);
    bus_read("R7 pm0 unchanged", 12'd92, 32'h80209828, 1'b0);
    chk_outputs("R7 R6 no side effect");
  endtask

  task automatic t_unmapped();
    int idxs [8] = '{3, 5, 7, 11, 17, 19, 24, 1023};
    foreach (idxs[k]) begin
      bus_write("R9 unmapped write", 12'(idxs[k] * 4), 32'h5A5A5A5A, 1'b1);
      bus_read("R9 unmapped read", 12'(idxs[k] * 4), 32'h0, 1'b1);
    end
    chk_outputs("R9 no side effect");
  endtask

  task automatic t_misaligned();
    bus_write("R10 misaligned write", 12'h001, 32'h00000000, 1'b1);
    bus_write("R10 misaligned write", 12'h022, 32'h00000000, 1'b1);
    bus_read("R10 misaligned read", 12'h006, 32'h0, 1'b1);
    chk_outputs("R10 no side effect");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h004; req_wdata = 32'h13579BDF;
    @(negedge clk);
    chk("R12 b2b write err", rsp_err, 1'b0);
    chk("R12 b2b write data zero", rsp_rdata, 32'h0);
    mdl[1] = stored(1, 32'h13579BDF);
    chk("R11 output updated", pdiv0_o, mdl[1]);
    req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 b2b read valid", rsp_valid, 1'b1);
    chk("R11 b2b read data", rsp_rdata, mdl[1]);
    @(negedge clk);
    chk("R1 idle after b2b", rsp_valid, 1'b0);
  endtask

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_fixed();
    t_unmapped();
    t_misaligned();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule